// File: doc/BRIEF.md
# Backup Supply Switchover Controller

This controller decides which source feeds a protected rail: the main supply or a backup source. It acts on four synchronous comparator flags. These report that the main supply is under the reset threshold, that it is under the backup voltage, that it is deeply under the backup voltage, and that a backup source is present. It drives one enable for the main path switch and one for the backup path switch. It also raises a backup-mode flag, forces the power-fail indication, and powers down the monitoring comparators during deep undervoltage.

Each flag passes through its own filter before the state machine acts on it. A flag change is accepted only after it has held for `STABLE_CYC` consecutive clocks. The filter stands in for the analog hysteresis. The rail moves to backup only when the main supply is both under threshold and under the backup voltage, and only with a backup source present. It returns to main as soon as the threshold flag clears. Every changeover spends exactly one clock with both switches open.

Top module: `bkup_switch_ctrl`

## Requirements
- R1: During reset both switch enables are 0. The reset is released two clocks after `rst_n` rises. After release, the filters capture the raw flags on the first clock. On the next clock the block goes either to the main path (`main_sw_en_o`=1) or directly to the backup path (`bk_sw_en_o`=1) if the backup entry condition of R2 holds.
- R2: From the main path, the block starts a changeover to backup only when the filtered flags `main_low_i`, `main_below_bk_i` and `bk_present_i` are all 1. All flags are active-high.
- R3: If the main supply is under threshold but not under the backup voltage, the main path stays enabled.
- R4: In backup, a filtered `main_low_i` of 0 starts the return to main, regardless of `main_below_bk_i`.
- R5: While the backup path is enabled, `bk_mode_o`=1 and `pf_force_low_o`=1. `bk_mode_o` is the indication that disables the watchdog and the power-fail input. Outside backup, both outputs are 0.
- R6: `cmp_pwrdn_o` is 1 exactly when the backup path is enabled and the filtered `main_deep_i` is 1.
- R7: With `bk_present_i`=0, no combination of the other flags enables the backup path.
- R8: The two enables are never 1 together. Each changeover has exactly one clock with both at 0.
- R9: A raw flag that differs from its filtered value for fewer than `STABLE_CYC` consecutive clocks has no effect. One that differs for `STABLE_CYC` clocks is accepted on the last of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_low_i | input | 1 | Main supply under reset threshold |
| main_below_bk_i | input | 1 | Main supply under backup voltage |
| main_deep_i | input | 1 | Main supply more than the margin under backup |
| bk_present_i | input | 1 | Backup source present |
| main_sw_en_o | output | 1 | Main path switch enable |
| bk_sw_en_o | output | 1 | Backup path switch enable |
| bk_mode_o | output | 1 | Backup mode; disables watchdog and power-fail input |
| pf_force_low_o | output | 1 | Forces power-fail indication low |
| cmp_pwrdn_o | output | 1 | Powers down monitoring comparators |

## Verification
The bench targets four corner cases, each with its failure symptom:
- A main supply that is under threshold but still above backup. A design that entered backup on the threshold flag alone would switch there.
- An absent backup source. A design that ignored presence would move the rail onto a dead source.
- An exit from backup while the main supply is still under the backup voltage. A design that required both flags to clear would stick in backup.
- Glitches shorter than the filter window, and the changeover cycles themselves. A design with a short counter would react to noise, and a design without the gap cycle would close both switches at once.

It also restarts under full backup conditions and expects the block to land on the backup path directly.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int NFLAG    = 4;
  localparam int FL_LOW   = 0;
  localparam int FL_BELOW = 1;
  localparam int FL_DEEP  = 2;
  localparam int FL_PRES  = 3;

  typedef enum logic [2:0] {
    ST_INIT     = 3'd0,
    ST_MAIN     = 3'd1,
    ST_GAP_BK   = 3'd2,
    ST_BK       = 3'd3,
    ST_GAP_MAIN = 3'd4
  } sw_state_e;
endpackage

// File: rtl/bsw_rst_sync.sv
module bsw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_s_n = s2_q;
endmodule

// File: rtl/bsw_flag_filter.sv
module bsw_flag_filter #(
  parameter int NFLAG      = 4,
  parameter int STABLE_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] raw_i,
  output logic             primed_o,
  output logic [NFLAG-1:0] flt_o
);
  localparam int CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(STABLE_CYC - 1);

  logic primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed_q <= 1'b0;
    else        primed_q <= 1'b1;
  end

  assign primed_o = primed_q;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic [CW-1:0] cnt_q, cnt_d;
    logic          flt_q, flt_d;
    logic          cnt_en, flt_en;

    always_comb begin
      cnt_d  = '0;
      flt_d  = flt_q;
      cnt_en = 1'b0;
      flt_en = 1'b0;
      if (!primed_q) begin
        flt_d  = raw_i[g];
        flt_en = 1'b1;
        cnt_en = 1'b1;
      end else if (raw_i[g] == flt_q) begin
        cnt_en = (cnt_q != '0);
      end else if (cnt_q == LIM) begin
        flt_d  = raw_i[g];
        flt_en = 1'b1;
        cnt_en = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        flt_q <= 1'b0;
      end else begin
        if (cnt_en) cnt_q <= cnt_d;
        if (flt_en) flt_q <= flt_d;
      end
    end

    assign flt_o[g] = flt_q;
  end
endmodule

// File: rtl/bsw_fsm.sv
module bsw_fsm
  import bsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             primed_i,
  input  logic [NFLAG-1:0] flt_i,
  output sw_state_e        state_o
);
  sw_state_e state_q, state_d;
  logic      go_bk;

  assign go_bk = flt_i[FL_LOW] & flt_i[FL_BELOW] & flt_i[FL_PRES];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:     if (primed_i) state_d = go_bk ? ST_BK : ST_MAIN;
      ST_MAIN:     if (go_bk) state_d = ST_GAP_BK;
      ST_GAP_BK:   state_d = go_bk ? ST_BK : ST_MAIN;
      ST_BK:       if (!flt_i[FL_LOW]) state_d = ST_GAP_MAIN;
      ST_GAP_MAIN: state_d = ST_MAIN;
      default:     state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_INIT;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/bkup_switch_ctrl.sv
module bkup_switch_ctrl
  import bsw_pkg::*;
#(
  parameter int STABLE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic main_low_i,
  input  logic main_below_bk_i,
  input  logic main_deep_i,
  input  logic bk_present_i,
  output logic main_sw_en_o,
  output logic bk_sw_en_o,
  output logic bk_mode_o,
  output logic pf_force_low_o,
  output logic cmp_pwrdn_o
);
  logic             rst_s;
  logic             primed;
  logic [NFLAG-1:0] raw;
  logic [NFLAG-1:0] flt;
  sw_state_e        state;

  assign raw[FL_LOW]   = main_low_i;
  assign raw[FL_BELOW] = main_below_bk_i;
  assign raw[FL_DEEP]  = main_deep_i;
  assign raw[FL_PRES]  = bk_present_i;

  bsw_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s)
  );

  bsw_flag_filter #(.NFLAG(NFLAG), .STABLE_CYC(STABLE_CYC)) u_flt (
    .clk      (clk),
    .rst_n    (rst_s),
    .raw_i    (raw),
    .primed_o (primed),
    .flt_o    (flt)
  );

  bsw_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_s),
    .primed_i (primed),
    .flt_i    (flt),
    .state_o  (state)
  );

  assign main_sw_en_o   = (state == ST_MAIN);
  assign bk_sw_en_o     = (state == ST_BK);
  assign bk_mode_o      = (state == ST_BK);
  assign pf_force_low_o = (state == ST_BK);
  assign cmp_pwrdn_o    = (state == ST_BK) & flt[FL_DEEP];
endmodule

// File: rtl/bsw_checker.sv
module bsw_checker
  import bsw_pkg::*;
(
  input logic             clk,
  input logic             rst_s,
  input logic [NFLAG-1:0] flt,
  input logic             main_en,
  input logic             bk_en,
  input logic             bk_mode,
  input logic             pf_low,
  input logic             pwrdn
);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_s)
    !(main_en && bk_en));

  a_r8_gap_to_bk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(bk_en) |-> !$past(main_en));

  a_r8_gap_to_main: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(main_en) |-> !$past(bk_en));

  a_r2_entry_cond: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(bk_en) |-> $past(flt[FL_LOW] && flt[FL_BELOW]));

  a_r7_needs_source: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(bk_en) |-> $past(flt[FL_PRES]));

  a_r3_hold_main: assert property (@(posedge clk) disable iff (!rst_s)
    (main_en && flt[FL_LOW] && !flt[FL_BELOW]) |=> main_en);

  a_r4_exit: assert property (@(posedge clk) disable iff (!rst_s)
    (bk_en && !flt[FL_LOW]) |=> !bk_en);

  a_r5_mode_flags: assert property (@(posedge clk) disable iff (!rst_s)
    bk_en |-> (bk_mode && pf_low));

  a_r6_pwrdn_in_bk: assert property (@(posedge clk) disable iff (!rst_s)
    pwrdn |-> bk_mode);
endmodule

bind bkup_switch_ctrl bsw_checker u_chk (
  .clk     (clk),
  .rst_s   (rst_s),
  .flt     (flt),
  .main_en (main_sw_en_o),
  .bk_en   (bk_sw_en_o),
  .bk_mode (bk_mode_o),
  .pf_low  (pf_force_low_o),
  .pwrdn   (cmp_pwrdn_o)
);

// File: tb/sim_bkup_switch_ctrl.sv
module sim_bkup_switch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int STABLE     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lo = 1'b0, bl = 1'b0, dp = 1'b0, pr = 1'b0;
  logic main_en, bk_en, bk_mode, pf_low, pwrdn;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkup_switch_ctrl #(.STABLE_CYC(STABLE)) u0 (
    .clk(clk), .rst_n(rst_n),
    .main_low_i(lo), .main_below_bk_i(bl), .main_deep_i(dp), .bk_present_i(pr),
    .main_sw_en_o(main_en), .bk_sw_en_o(bk_en), .bk_mode_o(bk_mode),
    .pf_force_low_o(pf_low), .cmp_pwrdn_o(pwrdn)
  );

  // Reference model: 0 init, 1 main, 2 gap to backup, 3 backup, 4 gap to main
  int m_s1 = 0, m_s2 = 0, m_primed = 0, m_state = 0;
  int m_f[4] = '{0, 0, 0, 0};
  int m_cnt[4] = '{0, 0, 0, 0};

  always @(posedge clk or negedge rst_n) begin
    int raw[4];
    int go;
    raw = '{int'(lo), int'(bl), int'(dp), int'(pr)};
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_primed = 0; m_state = 0;
      for (int i = 0; i < 4; i++) begin m_f[i] = 0; m_cnt[i] = 0; end
    end else if (m_s2 == 0) begin
      m_s2 = m_s1; m_s1 = 1;
    end else if (m_primed == 0) begin
      m_primed = 1;
      for (int i = 0; i < 4; i++) begin m_f[i] = raw[i]; m_cnt[i] = 0; end
    end else begin
      go = m_f[0] && m_f[1] && m_f[3];
      case (m_state)
        0: m_state = go ? 3 : 1;
        1: if (go) m_state = 2;
        2: m_state = go ? 3 : 1;
        3: if (!m_f[0]) m_state = 4;
        default: m_state = 1;
      endcase
      for (int i = 0; i < 4; i++) begin
        if (raw[i] == m_f[i]) m_cnt[i] = 0;
        else if (m_cnt[i] == STABLE - 1) begin m_f[i] = raw[i]; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end
    end
  end

  task automatic cmp(input logic act, input logic exp, input string req, input string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      cmp(main_en, m_state == 1, cur_req, "main_sw_en");
      cmp(bk_en,   m_state == 3, cur_req, "bk_sw_en");
      cmp(bk_mode, m_state == 3, "R5", "bk_mode");
      cmp(pf_low,  m_state == 3, "R5", "pf_force_low");
      cmp(pwrdn,   (m_state == 3) && (m_f[2] != 0), "R6", "cmp_pwrdn");
      cmp(main_en && bk_en, 1'b0, "R8", "both enabled");
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    @(negedge clk);
    #1;
    cmp(act, exp, req, what);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R1: reset, main supply healthy
    cur_req = "R1";
    wait_cyc(3);
    chk(main_en, 1'b0, "R1", "main off in reset");
    chk(bk_en, 1'b0, "R1", "bk off in reset");
    wait_cyc(1);
    rst_n = 1'b1;
    wait_cyc(6);
    chk(main_en, 1'b1, "R1", "main after reset");

    // R9: short glitch on threshold flag, then low with both other flags set
    cur_req = "R9";
    bl = 1'b1; pr = 1'b1;
    wait_cyc(1);
    lo = 1'b1;
    wait_cyc(STABLE - 1);
    lo = 1'b0;
    wait_cyc(10);
    chk(main_en, 1'b1, "R9", "glitch ignored");
    bl = 1'b0; pr = 1'b0;
    wait_cyc(10);

    // R3: under threshold, above backup
    cur_req = "R3";
    lo = 1'b1;
    wait_cyc(12);
    chk(main_en, 1'b1, "R3", "stay on main");

    // R7: under both, no backup source
    cur_req = "R7";
    bl = 1'b1; dp = 1'b1;
    wait_cyc(12);
    chk(bk_en, 1'b0, "R7", "no switch without source");
    chk(main_en, 1'b1, "R7", "main kept");
    dp = 1'b0;
    wait_cyc(10);

    // R2 / R8 / R5: source appears, changeover to backup
    cur_req = "R2";
    pr = 1'b1;
    wait_cyc(12);
    chk(bk_en, 1'b1, "R2", "entered backup");
    chk(main_en, 1'b0, "R2", "main off in backup");
    chk(bk_mode, 1'b1, "R5", "bk_mode");
    chk(pf_low, 1'b1, "R5", "pf forced");

    // R6: deep undervoltage in backup
    cur_req = "R6";
    dp = 1'b1;
    wait_cyc(10);
    chk(pwrdn, 1'b1, "R6", "comparators down");
    dp = 1'b0;
    wait_cyc(10);
    chk(pwrdn, 1'b0, "R6", "comparators up");

    // R4: threshold recovers while still under backup voltage
    cur_req = "R4";
    lo = 1'b0;
    wait_cyc(12);
    chk(main_en, 1'b1, "R4", "back to main");
    chk(bk_en, 1'b0, "R4", "backup off");
    chk(pf_low, 1'b0, "R5", "pf released");

    // R1: restart under full backup conditions
    cur_req = "R1";
    rst_n = 1'b0;
    lo = 1'b1; bl = 1'b1; pr = 1'b1;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(6);
    chk(bk_en, 1'b1, "R1", "start on backup");
    chk(main_en, 1'b0, "R1", "main off at start");
    wait_cyc(4);

    finish_run();
  end
endmodule